// File: doc/BRIEF.md
# Function-Level Reset Handshake Controller

This block sits between the link-side reset signalling of a multi-function endpoint and the user logic that implements each function. Two level vectors, one for physical functions and one for virtual functions, mark which functions have a function-level reset under way. For each marked function the controller gives the user logic a one-cycle reset pulse. It then waits for that function's completion strobe and raises the matching done bit toward the link side. The done bit stays high until the in-progress bit falls.

A free-running millisecond timebase, derived from the clock frequency, enforces a completion deadline for each function. A function whose user logic does not answer within the deadline raises a sticky timeout flag and is reported done anyway, so the link side is never left waiting. A hot-reset input overrides all of this. While it is high, every function's reset output is held high, every done bit is cleared and every per-function state machine returns to idle, with no handshake involved.

Top module: `flr_handshake_ctrl`

## Requirements
- R1: A function's reset output pulses high for exactly one cycle, in the cycle after its in-progress bit is first sampled high while that function is idle. Functions whose in-progress bit is low get no pulse.
- R2: Physical and virtual functions are fully independent. Bit n of one vector never affects bit n of the other vector's reset, done or timeout outputs.
- R3: A function's done output rises one cycle after its user-done input is sampled high while it waits for completion. Done stays high for as long as the in-progress bit stays high.
- R4: Done falls one cycle after the in-progress bit is sampled low. Done is never high in a cycle that follows a cycle in which the in-progress bit was low.
- R5: If user-done does not arrive, the function times out on the DEADLINE_MS-th millisecond tick counted from the reset pulse. One tick occurs every CLK_FREQ_KHZ cycles. On timeout its timeout flag and its done output both rise together.
- R6: While a function is neither idle nor finished, a fall and re-rise of its in-progress bit is ignored. No second reset pulse is produced, and the handshake in progress completes normally.
- R7: While hot reset is sampled high, every reset output is high and every done output is low from the next cycle on. When hot reset falls, each function whose in-progress bit is still high starts a fresh handshake with a new one-cycle pulse.
- R8: A timeout flag is sticky. Neither the in-progress bit falling nor hot reset clears it; only the block reset does.
- R9: A user-done strobe for a function that is idle has no effect on its done output.
- R10: After the synchronous block reset, all reset, done and timeout outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| hot_reset_i | input | 1 | Reset all functions at once while high |
| pf_inprog_i | input | NUM_PF | Physical-function reset in progress, one bit each |
| vf_inprog_i | input | NUM_VF | Virtual-function reset in progress, one bit each |
| pf_user_done_i | input | NUM_PF | User logic finished resetting a physical function |
| vf_user_done_i | input | NUM_VF | User logic finished resetting a virtual function |
| pf_func_rst_o | output | NUM_PF | Reset to physical-function user logic |
| vf_func_rst_o | output | NUM_VF | Reset to virtual-function user logic |
| pf_done_o | output | NUM_PF | Physical-function reset complete |
| vf_done_o | output | NUM_VF | Virtual-function reset complete |
| pf_timeout_o | output | NUM_PF | Sticky deadline-missed flag, physical functions |
| vf_timeout_o | output | NUM_VF | Sticky deadline-missed flag, virtual functions |

## Verification
All outputs are registered. The reset pulse therefore appears one edge after the in-progress bit is sampled, and done appears one edge after user-done is sampled. Done clears one edge after in-progress falls, and hot reset takes effect one edge after it is sampled. The bench drives inputs and samples outputs on the falling edge, so each check reads the value due after exactly the counted number of rising edges. The timeout is checked as a window, because the millisecond timebase free-runs and its phase against the start is unknown. The flag must still be low 30 edges after the start and high by edge 42, for a bench setting of 10 cycles per tick and a 4-tick deadline.

// File: rtl/flr_pkg.sv
package flr_pkg;

  typedef enum logic [2:0] {
    FS_IDLE      = 3'd0,
    FS_RESETTING = 3'd1,
    FS_WAIT_USER = 3'd2,
    FS_DONE      = 3'd3,
    FS_TIMEOUT   = 3'd4
  } flr_state_e;

endpackage

// File: rtl/flr_ms_timebase.sv
module flr_ms_timebase #(
  parameter int TICKS_PER_MS = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic ms_tick_o
);

  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICKS_PER_MS - 1);

  logic [TW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      ms_tick_o <= 1'b0;
    end else begin
      if (div_q == LAST) begin
        div_q     <= '0;
        ms_tick_o <= 1'b1;
      end else begin
        div_q     <= div_q + 1'b1;
        ms_tick_o <= 1'b0;
      end
    end
  end

  generate
    if (TICKS_PER_MS > 1) begin : g_tick_chk
      // R5
      tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        ms_tick_o |=> !ms_tick_o);
    end
  endgenerate

endmodule

// File: rtl/flr_func_fsm.sv
module flr_func_fsm
  import flr_pkg::*;
#(
  parameter int DEADLINE_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick_i,
  input  logic hot_i,
  input  logic inprog_i,
  input  logic user_done_i,
  output logic func_rst_o,
  output logic done_o,
  output logic timeout_o
);

  localparam int MSW = $clog2(DEADLINE_MS + 1);
  localparam logic [MSW-1:0] LAST_TICK = MSW'(DEADLINE_MS - 1);

  flr_state_e     state_q, state_d;
  logic [MSW-1:0] ms_q, ms_d;
  logic           expire;

  assign expire = ms_tick_i && (ms_q == LAST_TICK);

  always_comb begin
    state_d = state_q;
    ms_d    = ms_q;
    if (hot_i) begin
      state_d = FS_IDLE;
      ms_d    = '0;
    end else begin
      case (state_q)
        FS_IDLE: begin
          ms_d = '0;
          if (inprog_i) state_d = FS_RESETTING;
        end
        FS_RESETTING: begin
          if (ms_tick_i) ms_d = ms_q + 1'b1;
          state_d = FS_WAIT_USER;
        end
        FS_WAIT_USER: begin
          if (ms_tick_i) ms_d = ms_q + 1'b1;
          if (user_done_i) begin
            state_d = inprog_i ? FS_DONE : FS_IDLE;
          end else if (expire) begin
            state_d = inprog_i ? FS_TIMEOUT : FS_IDLE;
          end
        end
        FS_DONE, FS_TIMEOUT: begin
          if (!inprog_i) state_d = FS_IDLE;
        end
        default: state_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FS_IDLE;
      ms_q       <= '0;
      func_rst_o <= 1'b0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      ms_q       <= ms_d;
      func_rst_o <= hot_i || (state_q == FS_IDLE && inprog_i);
      done_o     <= (state_d == FS_DONE) || (state_d == FS_TIMEOUT);
      if (!hot_i && state_q == FS_WAIT_USER && !user_done_i && expire)
        timeout_o <= 1'b1;
    end
  end

  // R1
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == FS_RESETTING && !hot_i) |=> !func_rst_o);

  // R4
  done_needs_inprog_chk: assert property (@(posedge clk) disable iff (rst)
    !inprog_i |=> !done_o);

  // R3
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> ($past(user_done_i) || timeout_o));

  // R7
  hot_all_chk: assert property (@(posedge clk) disable iff (rst)
    hot_i |=> (func_rst_o && !done_o));

  // R8
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> timeout_o);

  // R9
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == FS_IDLE && !inprog_i) |=> !done_o);

endmodule

// File: rtl/flr_func_bank.sv
module flr_func_bank #(
  parameter int NUM_FUNC    = 4,
  parameter int DEADLINE_MS = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ms_tick_i,
  input  logic                hot_i,
  input  logic [NUM_FUNC-1:0] inprog_i,
  input  logic [NUM_FUNC-1:0] user_done_i,
  output logic [NUM_FUNC-1:0] func_rst_o,
  output logic [NUM_FUNC-1:0] done_o,
  output logic [NUM_FUNC-1:0] timeout_o
);

  generate
    for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fn
      flr_func_fsm #(
        .DEADLINE_MS (DEADLINE_MS)
      ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ms_tick_i   (ms_tick_i),
        .hot_i       (hot_i),
        .inprog_i    (inprog_i[i]),
        .user_done_i (user_done_i[i]),
        .func_rst_o  (func_rst_o[i]),
        .done_o      (done_o[i]),
        .timeout_o   (timeout_o[i])
      );
    end
  endgenerate

  // R4
  bank_done_subset_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((done_o & ~$past(inprog_i)) == '0));

endmodule

// File: rtl/flr_handshake_ctrl.sv
module flr_handshake_ctrl #(
  parameter int NUM_PF       = 4,
  parameter int NUM_VF       = 16,
  parameter int CLK_FREQ_KHZ = 250000,
  parameter int DEADLINE_MS  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hot_reset_i,
  input  logic [NUM_PF-1:0] pf_inprog_i,
  input  logic [NUM_VF-1:0] vf_inprog_i,
  input  logic [NUM_PF-1:0] pf_user_done_i,
  input  logic [NUM_VF-1:0] vf_user_done_i,
  output logic [NUM_PF-1:0] pf_func_rst_o,
  output logic [NUM_VF-1:0] vf_func_rst_o,
  output logic [NUM_PF-1:0] pf_done_o,
  output logic [NUM_VF-1:0] vf_done_o,
  output logic [NUM_PF-1:0] pf_timeout_o,
  output logic [NUM_VF-1:0] vf_timeout_o
);

  localparam int TICKS_PER_MS = CLK_FREQ_KHZ;

  logic ms_tick;

  flr_ms_timebase #(
    .TICKS_PER_MS (TICKS_PER_MS)
  ) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .ms_tick_o (ms_tick)
  );

  flr_func_bank #(
    .NUM_FUNC    (NUM_PF),
    .DEADLINE_MS (DEADLINE_MS)
  ) u_pf_bank (
    .clk         (clk),
    .rst         (rst),
    .ms_tick_i   (ms_tick),
    .hot_i       (hot_reset_i),
    .inprog_i    (pf_inprog_i),
    .user_done_i (pf_user_done_i),
    .func_rst_o  (pf_func_rst_o),
    .done_o      (pf_done_o),
    .timeout_o   (pf_timeout_o)
  );

  flr_func_bank #(
    .NUM_FUNC    (NUM_VF),
    .DEADLINE_MS (DEADLINE_MS)
  ) u_vf_bank (
    .clk         (clk),
    .rst         (rst),
    .ms_tick_i   (ms_tick),
    .hot_i       (hot_reset_i),
    .inprog_i    (vf_inprog_i),
    .user_done_i (vf_user_done_i),
    .func_rst_o  (vf_func_rst_o),
    .done_o      (vf_done_o),
    .timeout_o   (vf_timeout_o)
  );

  // R7
  hot_vectors_chk: assert property (@(posedge clk) disable iff (rst)
    hot_reset_i |=> (&pf_func_rst_o && &vf_func_rst_o &&
                     pf_done_o == '0 && vf_done_o == '0));

endmodule

// File: tb/sim_flr_handshake_ctrl.sv
module sim_flr_handshake_ctrl;

  localparam int NPF = 4;
  localparam int NVF = 8;
  localparam int TPM = 10;
  localparam int DLM = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           hot = 1'b0;
  logic [NPF-1:0] pf_ip = '0, pf_ud = '0;
  logic [NVF-1:0] vf_ip = '0, vf_ud = '0;
  logic [NPF-1:0] pf_rst, pf_done, pf_to;
  logic [NVF-1:0] vf_rst, vf_done, vf_to;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flr_handshake_ctrl #(
    .NUM_PF(NPF), .NUM_VF(NVF), .CLK_FREQ_KHZ(TPM), .DEADLINE_MS(DLM)
  ) u0 (
    .clk(clk), .rst(rst), .hot_reset_i(hot),
    .pf_inprog_i(pf_ip), .vf_inprog_i(vf_ip),
    .pf_user_done_i(pf_ud), .vf_user_done_i(vf_ud),
    .pf_func_rst_o(pf_rst), .vf_func_rst_o(vf_rst),
    .pf_done_o(pf_done), .vf_done_o(vf_done),
    .pf_timeout_o(pf_to), .vf_timeout_o(vf_to)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic test_reset_state();
    chk("R10 pf rst", 32'(pf_rst), 0);
    chk("R10 vf rst", 32'(vf_rst), 0);
    chk("R10 pf done", 32'(pf_done), 0);
    chk("R10 vf done", 32'(vf_done), 0);
    chk("R10 timeout", 32'({pf_to, vf_to}), 0);
  endtask

  task automatic test_single();
    pf_ip[1] = 1'b1;
    tick(1);
    chk("R1 pulse pf1", 32'(pf_rst), 32'h2);
    chk("R1 no vf pulse", 32'(vf_rst), 0);
    tick(1);
    chk("R1 pulse width", 32'(pf_rst), 0);
    pf_ud[1] = 1'b1;
    tick(1);
    pf_ud[1] = 1'b0;
    chk("R3 done rise", 32'(pf_done), 32'h2);
    tick(3);
    chk("R3 done held", 32'(pf_done), 32'h2);
    pf_ip[1] = 1'b0;
    tick(1);
    chk("R4 done fall", 32'(pf_done), 0);
  endtask

  task automatic test_concurrent();
    pf_ip[0] = 1'b1; pf_ip[2] = 1'b1; vf_ip[5] = 1'b1;
    tick(1);
    chk("R1 concurrent pf", 32'(pf_rst), 32'h5);
    chk("R2 concurrent vf", 32'(vf_rst), 32'h20);
    tick(1);
    pf_ud[0] = 1'b1; vf_ud[5] = 1'b1;
    tick(1);
    pf_ud = '0; vf_ud = '0;
    chk("R2 pf done partial", 32'(pf_done), 32'h1);
    chk("R2 vf done", 32'(vf_done), 32'h20);
    pf_ud[2] = 1'b1;
    tick(1);
    pf_ud = '0;
    chk("R3 pf2 done", 32'(pf_done), 32'h5);
    pf_ip = '0; vf_ip = '0;
    tick(1);
    chk("R4 all clear pf", 32'(pf_done), 0);
    chk("R4 all clear vf", 32'(vf_done), 0);
  endtask

  task automatic test_ignore();
    logic seen;
    pf_ud[3] = 1'b1;
    tick(2);
    pf_ud[3] = 1'b0;
    chk("R9 idle user done", 32'(pf_done), 0);
    pf_ip[3] = 1'b1;
    tick(2);
    pf_ip[3] = 1'b0;
    tick(1);
    pf_ip[3] = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      if (pf_rst[3]) seen = 1'b1;
    end
    chk("R6 no second pulse", 32'(seen), 0);
    pf_ud[3] = 1'b1;
    tick(1);
    pf_ud[3] = 1'b0;
    chk("R6 handshake completes", 32'(pf_done), 32'h8);
    pf_ip[3] = 1'b0;
    tick(1);
    chk("R4 pf3 clear", 32'(pf_done), 0);
  endtask

  task automatic test_timeout();
    vf_ip[2] = 1'b1;
    tick(30);
    chk("R5 no early timeout", 32'(vf_to), 0);
    chk("R5 no early done", 32'(vf_done), 0);
    tick(12);
    chk("R5 timeout flag", 32'(vf_to), 32'h4);
    chk("R5 done on timeout", 32'(vf_done), 32'h4);
    chk("R2 pf unaffected", 32'(pf_to), 0);
    vf_ip[2] = 1'b0;
    tick(1);
    chk("R4 done clears", 32'(vf_done), 0);
    chk("R8 flag sticky", 32'(vf_to), 32'h4);
  endtask

  task automatic test_hot();
    pf_ip[0] = 1'b1; pf_ip[1] = 1'b1; vf_ip[0] = 1'b1;
    tick(2);
    pf_ud[1] = 1'b1;
    tick(1);
    pf_ud[1] = 1'b0;
    chk("R3 pf1 done pre-hot", 32'(pf_done), 32'h2);
    hot = 1'b1;
    tick(1);
    chk("R7 all pf rst", 32'(pf_rst), 32'hF);
    chk("R7 all vf rst", 32'(vf_rst), 32'hFF);
    chk("R7 done cleared", 32'({pf_done, vf_done}), 0);
    tick(2);
    chk("R7 rst held", 32'({pf_rst, vf_rst}), 32'hFFF);
    chk("R8 survives hot", 32'(vf_to), 32'h4);
    hot = 1'b0;
    tick(1);
    chk("R7 restart pf", 32'(pf_rst), 32'h3);
    chk("R7 restart vf", 32'(vf_rst), 32'h1);
    tick(1);
    pf_ud[0] = 1'b1; pf_ud[1] = 1'b1; vf_ud[0] = 1'b1;
    tick(1);
    pf_ud = '0; vf_ud = '0;
    chk("R7 fresh handshake done", 32'({pf_done, vf_done}), 32'h301);
    pf_ip = '0; vf_ip = '0;
    tick(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    test_reset_state();
    test_single();
    test_concurrent();
    test_ignore();
    test_timeout();
    test_hot();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule